// File: doc/BRIEF.md
# Completion Ring Writer with Phase Color

This block writes fixed 16-byte completion entries into a power-of-two circular ring on behalf of one command or crypto queue. An init operation sets the ring depth with a log2 size code and chooses whether the queue starts enabled and whether it raises an interrupt request. Codes outside the legal range are refused with a range-error status. A separate control operation enables or disables the queue without moving the ring position.

Each accepted completion request carries a status byte and the index of the finished descriptor. The block packs these into an entry and presents it on a single-cycle memory write port, addressed by ring slot. The top bit of the last entry byte holds a phase color. It starts at 1 and inverts every time the write position wraps from the last slot back to slot 0, so a consumer can tell new entries from stale ones without reading a producer index.

Top module: `cq_ring_writer`

## Requirements
- R1: After reset the queue is disabled, the write pointer is slot 0, the color is 1, and mem_we_o and irq_o are 0. A request presented after reset writes nothing.
- R2: Entry layout on mem_data_o: bits [7:0] status, bits [15:8] zero, bits [23:16] descriptor index low byte, bits [31:24] index high byte, bit 127 the color, and every other bit zero.
- R3: Successive entries go to slots 0, 1, 2, ... and wrap to 0 after slot (1 << size code) - 1.
- R4: The color in written entries is 1 until the first wrap and inverts on every wrap after that.
- R5: An init whose size code is below 2 or above 12 reports status 16 and leaves size, enable, interrupt setting, pointer and color unchanged. A legal init reports status 0. init_done_o pulses one cycle after init_valid_i.
- R6: Init flag bit 1 enables the queue at once. A request arriving while the queue is disabled is dropped and writes nothing.
- R7: A control operation of 0 disables the queue and 1 enables it. Neither moves the pointer or changes the color.
- R8: With init flag bit 0 set, irq_o is high for exactly one cycle, in the cycle after each write. With it clear, irq_o stays low.
- R9: A legal init returns the pointer to slot 0 and the color to 1. A request in the same cycle as any init is dropped.
- R10: An accepted request shows on mem_we_o exactly one cycle later, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_valid_i | input | 1 | Init operation strobe |
| init_size_i | input | 4 | Log2 ring depth code |
| init_flags_i | input | 2 | Bit 0 interrupt request, bit 1 enable now |
| init_done_o | output | 1 | Init result valid |
| init_status_o | output | 8 | 0 success, 16 out of range |
| ctrl_valid_i | input | 1 | Control operation strobe |
| ctrl_oper_i | input | 1 | 0 disable, 1 enable |
| req_valid_i | input | 1 | Completion request |
| req_status_i | input | 8 | Completion status byte |
| req_index_i | input | 16 | Completed descriptor index |
| mem_we_o | output | 1 | Entry write strobe |
| mem_addr_o | output | 12 | Ring slot |
| mem_data_o | output | 128 | Entry contents |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench drives the pointer through a full wrap and beyond at the smallest depth, so a design that flipped the color at the wrong slot or wrapped at the wrong mask shows a wrong color or address on the fifth or ninth entry. It sends illegal size codes on both sides of the range after the pointer has moved; a design that applied them, or reset the pointer anyway, lands the next entry at the wrong slot. It also collides an init with a request, disables and re-enables mid-ring, and checks that the largest size code does not wrap early, which catches mask and priority mistakes.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned ENTRY_BYTES = 16;
  localparam int unsigned ENTRY_W     = ENTRY_BYTES * 8;
  localparam logic [7:0]  ST_OK       = 8'd0;
  localparam logic [7:0]  ST_RANGE    = 8'd16;
endpackage

// File: rtl/cq_cfg.sv
module cq_cfg #(
  parameter int unsigned MIN_LG2 = 2,
  parameter int unsigned MAX_LG2 = 12,
  localparam int unsigned SIZE_W = $clog2(MAX_LG2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_valid_i,
  input  logic [SIZE_W-1:0] init_size_i,
  input  logic [1:0]        init_flags_i,
  input  logic              ctrl_valid_i,
  input  logic              ctrl_oper_i,
  output logic              size_ok_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              enabled_o,
  output logic              irq_en_o
);
  logic [SIZE_W-1:0] size_q;
  logic              ena_q, irq_q;

  assign size_ok_o = (init_size_i >= SIZE_W'(MIN_LG2)) && (init_size_i <= SIZE_W'(MAX_LG2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= SIZE_W'(MIN_LG2);
      ena_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (init_valid_i) begin
      if (size_ok_o) begin
        size_q <= init_size_i;
        irq_q  <= init_flags_i[0];
        ena_q  <= init_flags_i[1];
      end
    end else if (ctrl_valid_i) begin
      ena_q <= ctrl_oper_i;
    end
  end

  assign size_o    = size_q;
  assign enabled_o = ena_q;
  assign irq_en_o  = irq_q;

  // R5
  bad_init_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_valid_i && !size_ok_o |=> size_q == $past(size_q) && ena_q == $past(ena_q) && irq_q == $past(irq_q));
  // R7
  ctrl_sets_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_i && !init_valid_i |=> ena_q == $past(ctrl_oper_i));
endmodule

// File: rtl/cq_ptr.sv
module cq_ptr #(
  parameter int unsigned MAX_LG2 = 12,
  localparam int unsigned SIZE_W = $clog2(MAX_LG2 + 1),
  localparam int unsigned PTR_W  = MAX_LG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [PTR_W-1:0]  wptr_o,
  output logic              color_o
);
  logic [PTR_W-1:0] wptr_q, last_slot;
  logic             color_q, at_last;

  assign last_slot = {PTR_W{1'b1}} >> (SIZE_W'(MAX_LG2) - size_i);
  assign at_last   = (wptr_q == last_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      color_q <= 1'b1;
    end else if (clear_i) begin
      wptr_q  <= '0;
      color_q <= 1'b1;
    end else if (adv_i) begin
      if (at_last) begin
        wptr_q  <= '0;
        color_q <= ~color_q;
      end else begin
        wptr_q <= wptr_q + 1'b1;
      end
    end
  end

  assign wptr_o  = wptr_q;
  assign color_o = color_q;

  // R3 R4
  wrap_flips_color_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !clear_i && at_last |=> wptr_q == '0 && color_q != $past(color_q));
  // R9
  clear_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> wptr_q == '0 && color_q);
  // R3
  ptr_in_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !$stable(size_i) == 1'b0 |-> wptr_q <= last_slot);
endmodule

// File: rtl/cq_entry_fmt.sv
module cq_entry_fmt
  import cq_pkg::*;
#(
  parameter int unsigned IDX_W = 16,
  localparam int unsigned IDX_BYTES = IDX_W / 8
) (
  input  logic [7:0]         status_i,
  input  logic [IDX_W-1:0]   index_i,
  input  logic               color_i,
  output logic [ENTRY_W-1:0] entry_o
);
  // byte 0 status, byte 1 reserved, index little-endian from byte 2, color in MSB of last byte
  always_comb begin
    entry_o = '0;
    entry_o[7:0] = status_i;
    for (int b = 0; b < IDX_BYTES; b++) begin
      entry_o[16 + 8*b +: 8] = index_i[8*b +: 8];
    end
    entry_o[ENTRY_W-1] = color_i;
  end
endmodule

// File: rtl/cq_ring_writer.sv
module cq_ring_writer
  import cq_pkg::*;
#(
  parameter int unsigned MIN_LG2 = 2,
  parameter int unsigned MAX_LG2 = 12,
  parameter int unsigned IDX_W   = 16,
  localparam int unsigned SIZE_W = $clog2(MAX_LG2 + 1),
  localparam int unsigned PTR_W  = MAX_LG2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_valid_i,
  input  logic [SIZE_W-1:0]  init_size_i,
  input  logic [1:0]         init_flags_i,
  output logic               init_done_o,
  output logic [7:0]         init_status_o,
  input  logic               ctrl_valid_i,
  input  logic               ctrl_oper_i,
  input  logic               req_valid_i,
  input  logic [7:0]         req_status_i,
  input  logic [IDX_W-1:0]   req_index_i,
  output logic               mem_we_o,
  output logic [PTR_W-1:0]   mem_addr_o,
  output logic [ENTRY_W-1:0] mem_data_o,
  output logic               irq_o
);
  logic              size_ok, q_enabled, irq_en, accept;
  logic [SIZE_W-1:0] size;
  logic [PTR_W-1:0]  wptr;
  logic              color;
  logic [ENTRY_W-1:0] entry;

  cq_cfg #(.MIN_LG2(MIN_LG2), .MAX_LG2(MAX_LG2)) u_cfg (
    .clk_i, .rst_ni, .init_valid_i, .init_size_i, .init_flags_i,
    .ctrl_valid_i, .ctrl_oper_i,
    .size_ok_o(size_ok), .size_o(size), .enabled_o(q_enabled), .irq_en_o(irq_en)
  );

  // init wins over a same-cycle request
  assign accept = req_valid_i && q_enabled && !init_valid_i;

  cq_ptr #(.MAX_LG2(MAX_LG2)) u_ptr (
    .clk_i, .rst_ni,
    .clear_i(init_valid_i && size_ok), .adv_i(accept), .size_i(size),
    .wptr_o(wptr), .color_o(color)
  );

  cq_entry_fmt #(.IDX_W(IDX_W)) u_fmt (
    .status_i(req_status_i), .index_i(req_index_i), .color_i(color), .entry_o(entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o      <= 1'b0;
      mem_addr_o    <= '0;
      mem_data_o    <= '0;
      irq_o         <= 1'b0;
      init_done_o   <= 1'b0;
      init_status_o <= ST_OK;
    end else begin
      mem_we_o    <= accept;
      irq_o       <= mem_we_o && irq_en;
      init_done_o <= init_valid_i;
      if (accept) begin
        mem_addr_o <= wptr;
        mem_data_o <= entry;
      end
      if (init_valid_i) init_status_o <= size_ok ? ST_OK : ST_RANGE;
    end
  end

  // R6
  drop_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !q_enabled |=> !mem_we_o);
  // R8
  irq_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_we_o));
  // R10
  write_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(req_valid_i) && !$past(init_valid_i));
  // R5
  done_after_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> $past(init_valid_i));
endmodule

// File: tb/cq_ring_writer_tb_top.sv
module cq_ring_writer_tb_top;
  logic         clk = 0;
  logic         rst_ni = 0;
  logic         init_valid = 0;
  logic [3:0]   init_size = 0;
  logic [1:0]   init_flags = 0;
  logic         init_done;
  logic [7:0]   init_status;
  logic         ctrl_valid = 0;
  logic         ctrl_oper = 0;
  logic         req_valid = 0;
  logic [7:0]   req_status = 0;
  logic [15:0]  req_index = 0;
  logic         mem_we;
  logic [11:0]  mem_addr;
  logic [127:0] mem_data;
  logic         irq;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cq_ring_writer dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .init_valid_i(init_valid), .init_size_i(init_size), .init_flags_i(init_flags),
    .init_done_o(init_done), .init_status_o(init_status),
    .ctrl_valid_i(ctrl_valid), .ctrl_oper_i(ctrl_oper),
    .req_valid_i(req_valid), .req_status_i(req_status), .req_index_i(req_index),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_entry(input logic [7:0] st, input logic [15:0] idx, input bit col);
    return {col, 7'b0, 88'b0, idx[15:8], idx[7:0], 8'h00, st};
  endfunction

  task automatic send(input logic [7:0] st, input logic [15:0] idx, input bit exp_w,
                      input logic [11:0] exp_addr, input bit exp_col, input bit exp_irq, input string tag);
    @(negedge clk);
    req_valid = 1; req_status = st; req_index = idx;
    @(negedge clk);
    req_valid = 0;
    chk(mem_we == exp_w, {tag, " R10 we"}, 128'(mem_we), 128'(exp_w));
    if (exp_w) begin
      chk(mem_addr == exp_addr, {tag, " R3 addr"}, 128'(mem_addr), 128'(exp_addr));
      chk(mem_data == mk_entry(st, idx, exp_col), {tag, " R2 R4 data"}, mem_data, mk_entry(st, idx, exp_col));
    end
    @(negedge clk);
    chk(irq == exp_irq, {tag, " R8 irq"}, 128'(irq), 128'(exp_irq));
    chk(mem_we == 0, {tag, " R10 single"}, 128'(mem_we), 128'(0));
  endtask

  task automatic do_init(input logic [3:0] sz, input logic [1:0] fl, input logic [7:0] exp_st, input string tag);
    @(negedge clk);
    init_valid = 1; init_size = sz; init_flags = fl;
    @(negedge clk);
    init_valid = 0;
    chk(init_done && init_status == exp_st, {tag, " R5 status"}, 128'({init_done, init_status}), 128'({1'b1, exp_st}));
  endtask

  task automatic do_ctrl(input bit op);
    @(negedge clk);
    ctrl_valid = 1; ctrl_oper = op;
    @(negedge clk);
    ctrl_valid = 0;
  endtask

  task automatic t_reset;
    chk(!mem_we && !irq && !init_done, "R1 reset outputs", 128'({mem_we, irq, init_done}), 128'(0));
    send(8'h11, 16'h0001, 0, 0, 0, 0, "R1 disabled after reset");
  endtask

  task automatic t_wrap_small;
    do_init(4'd2, 2'b10, 8'd0, "R6 init size2");
    for (int i = 0; i < 9; i++) begin
      bit c = (i < 4) ? 1'b1 : (i < 8) ? 1'b0 : 1'b1;
      send(8'(i * 3 + 1), 16'h1234 + 16'(i) * 16'h0101, 1, 12'(i % 4), c, 0, "R3 R4 wrap");
    end
  endtask

  task automatic t_bad_init;
    do_init(4'd1, 2'b01, 8'd16, "R5 below");
    do_init(4'd13, 2'b01, 8'd16, "R5 above");
    send(8'hA0, 16'hBEEF, 1, 12'd1, 1, 0, "R5 cfg kept");
  endtask

  task automatic t_ctrl;
    do_ctrl(0);
    send(8'hA1, 16'h0002, 0, 0, 0, 0, "R7 disable drops");
    do_ctrl(1);
    send(8'hA2, 16'h0003, 1, 12'd2, 1, 0, "R7 pointer kept");
  endtask

  task automatic t_init_disabled_irq;
    do_init(4'd3, 2'b01, 8'd0, "R6 init no ena");
    send(8'hB0, 16'h0004, 0, 0, 0, 0, "R6 drop before enable");
    do_ctrl(1);
    send(8'hB1, 16'hFF00, 1, 12'd0, 1, 1, "R9 R8 restart irq");
    for (int i = 1; i < 8; i++) send(8'hB2, 16'(i), 1, 12'(i), 1, 1, "R3 size3");
    send(8'hB3, 16'h0009, 1, 12'd0, 0, 1, "R4 size3 wrap");
  endtask

  task automatic t_collide;
    @(negedge clk);
    init_valid = 1; init_size = 4'd12; init_flags = 2'b10;
    req_valid = 1; req_status = 8'hC0; req_index = 16'h0C0C;
    @(negedge clk);
    init_valid = 0; req_valid = 0;
    chk(mem_we == 0, "R9 collide drop", 128'(mem_we), 128'(0));
    chk(init_status == 8'd0, "R5 size12 ok", 128'(init_status), 128'(0));
    for (int i = 0; i < 5; i++) send(8'hC1, 16'(i), 1, 12'(i), 1, 0, "R9 R3 size12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1;
    @(negedge clk);
    t_reset;
    t_wrap_small;
    t_bad_init;
    t_ctrl;
    t_init_disabled_irq;
    t_collide;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule